// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is an 18-bit-wide first-in first-out buffer whose write side and read side run on unrelated clocks. Its depth is a power-of-two parameter from 256 to 4096 words. Every control input and status output is active low. The status outputs are full (or input-ready), empty (or output-ready), almost-empty, almost-full and half-full.

Two 12-bit threshold registers set where almost-empty and almost-full switch. They are written and read through the ordinary data buses while a load strobe is held low. A shared one-bit selector on each side steps through them: the empty threshold first, then the full threshold. A static mode input chooses between two modes. In standard mode a read request is needed to bring each word out. In fall-through mode the oldest word shows on the outputs by itself, and the full and empty outputs change their meaning.

Pointers cross between the clock domains as Gray code. Each flag is raised at once in the domain that owns it. Clearing a flag in response to the other side may take up to three cycles of the observing clock.

Top module: `pflag_fifo`

## Requirements
- R1: While the reset input is low, and after it, in standard mode: full_n=1, almost_full_n=1, half_full_n=1, empty_n=0, almost_empty_n=0, data_valid=0.
- R2: A write with wr_en_n=0 and load_n=1 stores din on the rising wclk edge unless the FIFO holds DEPTH words. A write while full is dropped and changes neither the contents nor the order.
- R3: In standard mode, a read with rd_en_n=0 and load_n=1 puts the oldest word on dout at the rising rclk edge. With rd_en_n=1, or while empty, dout keeps its value.
- R4: With load_n=0 and wr_en_n=0, din[11:0] goes into a threshold register at each wclk edge: empty threshold first, then full threshold, then back to the first. No word enters the FIFO.
- R5: With load_n=0 and rd_en_n=0, each rclk edge places a threshold register on dout[11:0] with dout[17:12]=0, in the same order as R4. No word leaves the FIFO.
- R6: After reset both thresholds read back as 31 for DEPTH=256, 63 for DEPTH=512 and 127 for larger depths.
- R7: almost_empty_n is 0 exactly when the stored word count is less than or equal to the empty threshold.
- R8: almost_full_n is 0 exactly when DEPTH minus the stored word count is less than or equal to the full threshold.
- R9: half_full_n is 0 exactly when the stored word count exceeds DEPTH/2.
- R10: In standard mode, full_n is 0 exactly when DEPTH words are stored, and empty_n is 0 exactly when none are stored.
- R11: In fall-through mode, full_n reads 0 while there is room to write and 1 when the memory is full. empty_n reads 0 while a valid word is on dout. After reset these are 0 and 1.
- R12: In fall-through mode, the oldest word appears on dout without a read request. A read advances dout to the next word, or sets empty_n to 1 when no further word is stored. A word held on dout no longer counts as stored.
- R13: data_valid is 1 only while out_en_n=0 and dout carries a word that was read, loaded back or fallen through since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwft | input | 1 | Static mode select: 1 = fall-through, 0 = standard |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| load_n | input | 1 | Threshold access strobe, active low |
| out_en_n | input | 1 | Enables the data_valid indication, active low |
| din | input | 18 | Write data / threshold value |
| dout | output | 18 | Read data / threshold readback |
| full_n | output | 1 | Full (standard) or input-ready (fall-through), active low |
| empty_n | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| almost_empty_n | output | 1 | Programmable almost-empty, active low |
| almost_full_n | output | 1 | Programmable almost-full, active low |
| half_full_n | output | 1 | More than half full, active low |
| data_valid | output | 1 | dout holds a delivered word and out_en_n is low |

## Verification
A write and a read can land in the same period of their own clocks. Each then moves a pointer that the other domain sees only after synchronization. The bench provokes this by streaming a hundred words in at the write clock while a reader pulls whenever empty_n reports data. The word order is judged against the arithmetic pattern, and the flags are judged once both sides have settled. In a second case a write is attempted while the FIFO is full and the next reads have to skip over it. A third case loads the thresholds back to back and reads them out. It proves that neither access moves the FIFO, and the full fill and drain sweep then tests every flag boundary against the loaded values.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int WORD_W = 18;
  localparam int OFF_W  = 12;

  // Threshold value loaded at reset, chosen by depth.
  function automatic int default_offset(input int depth);
    if (depth <= 256) return 31;
    else if (depth <= 512) return 63;
    else return 127;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int W     = 18
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = 9
) (
  input  logic                       wclk,
  input  logic                       wrst_n,
  input  logic                       fwft,
  input  logic                       wr_en_n,
  input  logic                       load_n,
  input  logic [dcf_pkg::WORD_W-1:0] din,
  input  logic [PW-1:0]              rgray_s,
  output logic                       mem_we,
  output logic [AW-1:0]              mem_waddr,
  output logic [PW-1:0]              wgray,
  output logic [dcf_pkg::OFF_W-1:0]  eoff,
  output logic [dcf_pkg::OFF_W-1:0]  foff,
  output logic                       full_n,
  output logic                       almost_full_n,
  output logic                       half_full_n
);
  localparam int OW   = dcf_pkg::OFF_W;
  localparam int DFLT = dcf_pkg::default_offset(DEPTH);

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rbin_s, level, free;
  logic [OW-1:0] eoff_q, eoff_d, foff_q, foff_d;
  logic          sel_q, sel_d;
  logic          full, push, load;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign level = wbin_q - rbin_s;
  assign free  = PW'(DEPTH) - level;
  assign full  = (level == PW'(DEPTH));
  assign push  = load_n & ~wr_en_n & ~full;
  assign load  = ~load_n & ~wr_en_n;

  always_comb begin
    wbin_d  = wbin_q;
    wgray_d = wgray_q;
    eoff_d  = eoff_q;
    foff_d  = foff_q;
    sel_d   = sel_q;
    if (push) begin
      wbin_d  = wbin_q + PW'(1);
      wgray_d = wbin_d ^ (wbin_d >> 1);
    end
    if (load) begin
      if (sel_q) foff_d = din[OW-1:0];
      else       eoff_d = din[OW-1:0];
      sel_d = ~sel_q;
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      eoff_q  <= OW'(DFLT);
      foff_q  <= OW'(DFLT);
      sel_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      eoff_q  <= eoff_d;
      foff_q  <= foff_d;
      sel_q   <= sel_d;
    end
  end

  assign mem_we        = push;
  assign mem_waddr     = wbin_q[AW-1:0];
  assign wgray         = wgray_q;
  assign eoff          = eoff_q;
  assign foff          = foff_q;
  assign full_n        = fwft ? full : ~full;
  assign almost_full_n = !(32'(free) <= 32'(foff_q));
  assign half_full_n   = !(32'(level) > DEPTH / 2);

  // R2: a write request while full must leave the write pointer alone
  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    (full && !wr_en_n) |=> $stable(wbin_q));
  // R4: a threshold load must not move the write pointer
  p_load_no_push_r4: assert property (@(posedge wclk) disable iff (!wrst_n)
    !load_n |=> $stable(wbin_q));
  // R10: the stored count never exceeds the depth
  p_level_cap_r10: assert property (@(posedge wclk) disable iff (!wrst_n)
    level <= PW'(DEPTH));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = 9
) (
  input  logic                       rclk,
  input  logic                       rrst_n,
  input  logic                       fwft,
  input  logic                       rd_en_n,
  input  logic                       load_n,
  input  logic                       out_en_n,
  input  logic [PW-1:0]              wgray_s,
  input  logic [dcf_pkg::WORD_W-1:0] mem_rdata,
  input  logic [dcf_pkg::OFF_W-1:0]  eoff,
  input  logic [dcf_pkg::OFF_W-1:0]  foff,
  output logic [AW-1:0]              mem_raddr,
  output logic [PW-1:0]              rgray,
  output logic [dcf_pkg::WORD_W-1:0] dout,
  output logic                       empty_n,
  output logic                       almost_empty_n,
  output logic                       data_valid
);
  localparam int WW = dcf_pkg::WORD_W;
  localparam int OW = dcf_pkg::OFF_W;

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0] wbin_s, level;
  logic [WW-1:0] q_q, q_d;
  logic          orv_q, orv_d;
  logic          sel_q, sel_d;
  logic          mem_empty, rd_req, rb, pop;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign level     = wbin_s - rbin_q;
  assign mem_empty = (level == '0);
  assign rd_req    = load_n & ~rd_en_n;
  assign rb        = ~load_n & ~rd_en_n;
  assign pop       = fwft ? (load_n & ~mem_empty & (~orv_q | rd_req))
                          : (rd_req & ~mem_empty);

  always_comb begin
    rbin_d  = rbin_q;
    rgray_d = rgray_q;
    q_d     = q_q;
    orv_d   = orv_q;
    sel_d   = sel_q;
    if (rb) begin
      q_d   = {{(WW-OW){1'b0}}, (sel_q ? foff : eoff)};
      sel_d = ~sel_q;
      orv_d = ~fwft;
    end else if (pop) begin
      q_d     = mem_rdata;
      rbin_d  = rbin_q + PW'(1);
      rgray_d = rbin_d ^ (rbin_d >> 1);
      orv_d   = 1'b1;
    end else if (fwft && rd_req) begin
      orv_d = 1'b0;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      q_q     <= '0;
      orv_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      q_q     <= q_d;
      orv_q   <= orv_d;
      sel_q   <= sel_d;
    end
  end

  assign mem_raddr      = rbin_q[AW-1:0];
  assign rgray          = rgray_q;
  assign dout           = q_q;
  assign empty_n        = fwft ? ~orv_q : ~mem_empty;
  assign almost_empty_n = !(32'(level) <= 32'(eoff));
  assign data_valid     = ~out_en_n & orv_q;

  // R3: a read request on an empty memory must not move the read pointer
  p_no_underflow_r3: assert property (@(posedge rclk) disable iff (!rrst_n)
    (mem_empty && !rd_en_n) |=> $stable(rbin_q));
  // R3: with no read request in standard mode the output holds
  p_hold_q_r3: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!fwft && rd_en_n) |=> $stable(q_q));
  // R5: a threshold readback must not move the read pointer
  p_rb_no_pop_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    !load_n |=> $stable(rbin_q));
  // R12: a presented fall-through word stays until a read takes it
  p_or_hold_r12: assert property (@(posedge rclk) disable iff (!rrst_n)
    (fwft && orv_q && rd_en_n) |=> orv_q);
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo #(
  parameter int DEPTH = 256
) (
  input  logic        wclk,
  input  logic        rclk,
  input  logic        rst_n,
  input  logic        fwft,
  input  logic        wr_en_n,
  input  logic        rd_en_n,
  input  logic        load_n,
  input  logic        out_en_n,
  input  logic [17:0] din,
  output logic [17:0] dout,
  output logic        full_n,
  output logic        empty_n,
  output logic        almost_empty_n,
  output logic        almost_full_n,
  output logic        half_full_n,
  output logic        data_valid
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int WW = dcf_pkg::WORD_W;
  localparam int OW = dcf_pkg::OFF_W;

  logic          wrst_n, rrst_n;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [WW-1:0] mem_rdata;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [OW-1:0] eoff, foff;

  // Reset asserts at once, releases two edges later in each domain.
  dcf_sync #(.W(1)) u_wrst (.clk(wclk), .rst_n(rst_n), .d(1'b1), .q(wrst_n));
  dcf_sync #(.W(1)) u_rrst (.clk(rclk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  dcf_mem #(.DEPTH(DEPTH), .AW(AW), .W(WW)) u_mem (
    .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  dcf_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .fwft(fwft), .wr_en_n(wr_en_n),
    .load_n(load_n), .din(din), .rgray_s(rgray_s), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .wgray(wgray), .eoff(eoff), .foff(foff),
    .full_n(full_n), .almost_full_n(almost_full_n), .half_full_n(half_full_n)
  );

  dcf_rd_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .fwft(fwft), .rd_en_n(rd_en_n),
    .load_n(load_n), .out_en_n(out_en_n), .wgray_s(wgray_s),
    .mem_rdata(mem_rdata), .eoff(eoff), .foff(foff), .mem_raddr(mem_raddr),
    .rgray(rgray), .dout(dout), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .data_valid(data_valid)
  );
endmodule

// File: tb/pflag_fifo_test.sv
`timescale 1ns/100ps
module pflag_fifo_test;
  localparam int DEPTH = 256;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n, fwft, wr_en_n, rd_en_n, load_n, out_en_n;
  logic [17:0] din, dout;
  logic full_n, empty_n, almost_empty_n, almost_full_n, half_full_n, data_valid;
  int n_chk = 0, n_fail = 0;

  pflag_fifo #(.DEPTH(DEPTH)) uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .load_n(load_n), .out_en_n(out_en_n), .din(din),
    .dout(dout), .full_n(full_n), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n),
    .half_full_n(half_full_n), .data_valid(data_valid)
  );

  always #2 wclk = ~wclk;                       // 250 MHz write clock
  initial begin #0.5; forever #3 rclk = ~rclk; end

  function automatic logic [17:0] pat(input int n);
    return 18'(n * 771 + 5);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic wr_word(input logic [17:0] d);
    @(negedge wclk); din = d; wr_en_n = 1'b0;
    @(negedge wclk); wr_en_n = 1'b1;
  endtask

  task automatic rd_word();
    @(negedge rclk); rd_en_n = 1'b0;
    @(negedge rclk); rd_en_n = 1'b1;
  endtask

  task automatic rb_word(output logic [17:0] v);
    @(negedge rclk); load_n = 1'b0; rd_en_n = 1'b0;
    @(negedge rclk); load_n = 1'b1; rd_en_n = 1'b1; v = dout;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge wclk); rst_n = 1'b0; fwft = mode;
    repeat (4) @(negedge wclk);
    rst_n = 1'b1;
    repeat (6) @(negedge rclk);
  endtask

  // Flag check in standard mode for a stored count n with thresholds e, f.
  task automatic chk_levels(input int n, input int e, input int f);
    chk("R7 almost_empty_n", 32'(almost_empty_n), 32'(!(n <= e)));
    chk("R8 almost_full_n", 32'(almost_full_n), 32'(!((DEPTH - n) <= f)));
    chk("R9 half_full_n", 32'(half_full_n), 32'(!(n > DEPTH / 2)));
    chk("R10 full_n", 32'(full_n), 32'(n != DEPTH));
    chk("R10 empty_n", 32'(empty_n), 32'(n != 0));
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [17:0] v;
    rst_n = 1'b0; fwft = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1;
    load_n = 1'b1; out_en_n = 1'b0; din = '0;
    repeat (5) @(negedge wclk);
    rst_n = 1'b1;
    repeat (10) @(negedge rclk);

    // R1 reset state
    chk("R1 full_n", 32'(full_n), 1);
    chk("R1 almost_full_n", 32'(almost_full_n), 1);
    chk("R1 half_full_n", 32'(half_full_n), 1);
    chk("R1 empty_n", 32'(empty_n), 0);
    chk("R1 almost_empty_n", 32'(almost_empty_n), 0);
    chk("R1 data_valid", 32'(data_valid), 0);

    // R6 defaults read back, R5 upper bits zero
    rb_word(v); chk("R6 empty threshold default", 32'(v), 31);
    rb_word(v); chk("R6 full threshold default", 32'(v), 31);

    // R4 load thresholds back to back
    @(negedge wclk); load_n = 1'b0; wr_en_n = 1'b0; din = 18'h3F028;
    @(negedge wclk); din = 18'd25;
    @(negedge wclk); load_n = 1'b1; wr_en_n = 1'b1;
    settle();
    chk("R4 no word stored by load", 32'(empty_n), 0);
    rb_word(v); chk("R5 empty threshold readback", 32'(v), 40);
    rb_word(v); chk("R5 full threshold readback", 32'(v), 25);
    settle();
    chk("R5 no word removed by readback", 32'(empty_n), 0);

    // R7..R10 fill sweep over every count
    for (int n = 1; n <= DEPTH; n++) begin
      wr_word(pat(n));
      settle();
      chk_levels(n, 40, 25);
    end

    // R2 write while full is dropped
    wr_word(18'h3FFFF);
    settle();
    chk("R2 full_n stays low", 32'(full_n), 0);

    // R3 drain sweep
    for (int i = 0; i < DEPTH; i++) begin
      rd_word();
      chk("R3 read order", 32'(dout), 32'(pat(i + 1)));
      settle();
      chk_levels(DEPTH - 1 - i, 40, 25);
    end

    // R3 read while empty holds; R2 dropped word never appears
    rd_word();
    chk("R3 empty read holds dout", 32'(dout), 32'(pat(DEPTH)));
    settle();
    chk("R3 dout holds with rd_en_n high", 32'(dout), 32'(pat(DEPTH)));
    chk("R2 dropped word absent", 32'(empty_n), 0);

    // R13 output enable only gates data_valid
    chk("R13 data_valid with out_en_n low", 32'(data_valid), 1);
    @(negedge rclk); out_en_n = 1'b1; #0.1;
    chk("R13 data_valid with out_en_n high", 32'(data_valid), 0);
    @(negedge rclk); out_en_n = 1'b0;

    // R2/R3 concurrent write and read streaming
    fork
      begin
        for (int k = 0; k < 100; k++) begin
          @(negedge wclk); wr_en_n = 1'b0; din = pat(1000 + k);
        end
        @(negedge wclk); wr_en_n = 1'b1;
      end
      begin
        int got;
        got = 0;
        while (got < 100) begin
          @(negedge rclk);
          if (!rd_en_n) begin
            chk("R3 streamed order", 32'(dout), 32'(pat(1000 + got)));
            got++;
          end
          rd_en_n = (got < 100 && empty_n) ? 1'b0 : 1'b1;
        end
        rd_en_n = 1'b1;
      end
    join
    settle();
    chk_levels(0, 40, 25);

    // R11 fall-through reset state
    do_reset(1'b1);
    chk("R11 input-ready after reset", 32'(full_n), 0);
    chk("R11 output-ready after reset", 32'(empty_n), 1);
    chk("R1 almost_full_n after reset", 32'(almost_full_n), 1);

    // R12 fall-through without a read request
    wr_word(pat(2000));
    settle();
    chk("R12 first word falls through", 32'(dout), 32'(pat(2000)));
    chk("R11 output-ready asserted", 32'(empty_n), 0);
    chk("R13 data_valid in fall-through", 32'(data_valid), 1);
    chk("R12 presented word not counted", 32'(almost_empty_n), 0);
    wr_word(pat(2001));
    wr_word(pat(2002));
    settle();
    chk("R12 dout held without read", 32'(dout), 32'(pat(2000)));
    rd_word();
    chk("R12 read advances", 32'(dout), 32'(pat(2001)));
    settle();
    rd_word();
    chk("R12 read advances again", 32'(dout), 32'(pat(2002)));
    chk("R11 output-ready still asserted", 32'(empty_n), 0);
    settle();
    rd_word();
    chk("R12 last read clears output-ready", 32'(empty_n), 1);

    // R11 memory full in fall-through mode: DEPTH stored plus one presented
    for (int k = 0; k <= DEPTH; k++) wr_word(pat(3000 + k));
    settle();
    chk("R11 input-ready cleared when full", 32'(full_n), 1);
    chk("R9 half_full_n in fall-through", 32'(half_full_n), 0);
    chk("R12 oldest word presented", 32'(dout), 32'(pat(3000)));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule